// File: doc/BRIEF.md
# Complementary PWM Timer with Dead Time

This block is a 16-bit up-counting PWM timer that drives a complementary pair of outputs for one leg of a half-bridge. A power-of-two prescaler turns the system clock into timer ticks. On each tick the counter advances toward a reload value and is compared against a PWM value. The match sets the primary output's underlying level to the selected polarity, and the reload returns it to the opposite level. The second output always follows the inverse of that underlying level.

Both outputs pass through a dead-time stage. It holds off each low-to-high transition for a programmed number of timer ticks and lets each high-to-low transition through at once. As a result, the two switches of the bridge are never driven on together. Software configures the timer through a plain write port with three register addresses. While the timer is disabled, both outputs are low, the counter keeps its value and the prescaler is cleared.

Top module: `pwm_deadband_timer`

## Requirements
- R1: A write with `wrAddr`=0 loads the control word: bit 0 enable, bit 1 polarity, bits 4:2 prescale select, bits 7:5 dead-time ticks. `wrAddr`=1 loads the PWM value and `wrAddr`=2 loads the reload value. A write to `wrAddr`=3 changes nothing observable.
- R2: A timer tick occurs once every 2^P clock cycles, where P is the prescale select (0..7). The prescaler is cleared while the timer is disabled. After an enable write, the count first advances on the 2^P-th rising clock edge that follows the write edge.
- R3: On each tick the count increments by one. When the count is at or above the reload value, the next tick returns it to 1. After reset the count is 0.
- R4: The primary underlying level equals the polarity bit while the count lies from the PWM value up to the reload value. Otherwise it is the inverse of the polarity bit. A PWM value of 1 keeps it at the polarity level for the whole period.
- R5: The complementary underlying level is always the inverse of the primary underlying level.
- R6: Each output's low-to-high transition is delayed by D timer ticks, where D is the dead-time field (0 means no delay). High-to-low transitions are immediate. An underlying high phase shorter than D ticks leaves that output low for the whole phase.
- R7: While the enable bit is 0, both outputs are low and the count holds its value.
- R8: `pwmOut` and `pwmOutN` are never high in the same cycle.
- R9: After reset both outputs are low, the count is 0 and the timer is disabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register select for the write |
| wrData | input | 16 | Write data |
| pwmOut | output | 1 | Primary PWM output after dead time |
| pwmOutN | output | 1 | Complementary PWM output after dead time |
| count | output | 16 | Current counter value |

## Verification
The embedded properties are checked on every cycle. They cover four behaviours: the outputs never overlap, no tick is issued while the timer is off, the count is held while disabled, and the count wraps to 1 after a reload tick.

The duty of each output as a function of prescale, polarity, dead time and compare values is a property of whole periods, so only the bench's scenarios can show it. The same applies to the swallowed short pulse, the restart alignment of the prescaler and the ignored register address. The bench measures these by counting high cycles over complete periods and by sampling the count edge by edge after an enable.

// File: rtl/pwm_dt_pkg.sv
package pwm_dt_pkg;
  // Strobes handed from the control section to the datapath.
  typedef struct packed {
    logic enable;  // timer running
    logic tick;    // one prescaled timer tick this cycle
  } pwmStrobe_t;

  typedef enum logic [1:0] {
    REG_CTRL   = 2'd0,
    REG_PWM    = 2'd1,
    REG_RELOAD = 2'd2,
    REG_SPARE  = 2'd3
  } pwmReg_e;
endpackage

// File: rtl/pwm_dt_ctrl.sv
module pwm_dt_ctrl
  import pwm_dt_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int PRES_W = 3,
  parameter int DEAD_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        wrAddr,
  input  logic [CNT_W-1:0]  wrData,
  output pwmStrobe_t        strobe,
  output logic              polarity,
  output logic [DEAD_W-1:0] deadTicks,
  output logic [CNT_W-1:0]  pwmVal,
  output logic [CNT_W-1:0]  reloadVal
);
  // Control word layout
  localparam int EN_BIT   = 0;
  localparam int POL_BIT  = 1;
  localparam int PRES_LSB = 2;
  localparam int DEAD_LSB = PRES_LSB + PRES_W;
  // Prescaler width covers the largest division 2^(2^PRES_W - 1)
  localparam int DIV_W    = (1 << PRES_W) - 1;

  logic              enable;
  logic [PRES_W-1:0] presSel;
  logic [DIV_W-1:0]  divCnt;
  logic [DIV_W-1:0]  divMask;
  logic              tick;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enable    <= 1'b0;
      polarity  <= 1'b0;
      presSel   <= '0;
      deadTicks <= '0;
      pwmVal    <= '0;
      reloadVal <= '0;
    end else if (wrEn) begin
      unique case (pwmReg_e'(wrAddr))
        REG_CTRL: begin
          enable    <= wrData[EN_BIT];
          polarity  <= wrData[POL_BIT];
          presSel   <= wrData[PRES_LSB +: PRES_W];
          deadTicks <= wrData[DEAD_LSB +: DEAD_W];
        end
        REG_PWM:    pwmVal    <= wrData;
        REG_RELOAD: reloadVal <= wrData;
        default: ;
      endcase
    end
  end

  // Prescaler: cleared while disabled, free-running while enabled
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        divCnt <= '0;
    else if (!enable) divCnt <= '0;
    else              divCnt <= divCnt + DIV_W'(1);
  end

  assign divMask = ~({DIV_W{1'b1}} << presSel);
  assign tick    = enable && ((divCnt & divMask) == divMask);

  assign strobe.enable = enable;
  assign strobe.tick   = tick;
endmodule

// File: rtl/pwm_dt_datapath.sv
module pwm_dt_datapath
  import pwm_dt_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DEAD_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  pwmStrobe_t        strobe,
  input  logic              polarity,
  input  logic [DEAD_W-1:0] deadTicks,
  input  logic [CNT_W-1:0]  pwmVal,
  input  logic [CNT_W-1:0]  reloadVal,
  output logic              pwmOut,
  output logic              pwmOutN,
  output logic [CNT_W-1:0]  count
);
  localparam int NUM_CH = 2;  // 0: primary, 1: complement

  logic              atReload;
  logic              rawActive;
  logic              priLevel;
  logic [NUM_CH-1:0] want;
  logic [NUM_CH-1:0] drive;

  assign atReload = (count >= reloadVal);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            count <= '0;
    else if (strobe.tick) count <= atReload ? CNT_W'(1) : count + CNT_W'(1);
  end

  // Underlying phase: set at compare match, cleared at reload
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                rawActive <= 1'b0;
    else if (!strobe.enable)  rawActive <= 1'b0;
    else if (strobe.tick) begin
      if (atReload)                              rawActive <= (pwmVal == CNT_W'(1));
      else if ((count + CNT_W'(1)) == pwmVal)    rawActive <= 1'b1;
    end
  end

  assign priLevel = rawActive ? polarity : ~polarity;
  assign want[0]  = strobe.enable &  priLevel;
  assign want[1]  = strobe.enable & ~priLevel;

  // Dead-time stage per output: rising edges wait deadTicks ticks
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_dead
    logic [DEAD_W-1:0] waitCnt;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                 waitCnt <= '0;
      else if (!want[ch])                        waitCnt <= '0;
      else if (strobe.tick && waitCnt < deadTicks) waitCnt <= waitCnt + DEAD_W'(1);
    end
    assign drive[ch] = want[ch] && (waitCnt >= deadTicks);
  end

  assign pwmOut  = drive[0];
  assign pwmOutN = drive[1];

  // R2: the control section issues no tick while the timer is off
  a_r2_no_tick_off: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.enable |-> !strobe.tick);

  // R7: the count is frozen while disabled
  a_r7_count_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.enable |=> $stable(count));

  // R3: a reload tick brings the count back to 1
  a_r3_wrap_to_one: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.tick && count >= reloadVal) |=> (count == CNT_W'(1)));

  // R8: the pair is never on together
  a_r8_no_overlap: assert property (@(posedge clk) disable iff (!rstN)
    !(pwmOut && pwmOutN));
endmodule

// File: rtl/pwm_deadband_timer.sv
module pwm_deadband_timer
  import pwm_dt_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int PRES_W = 3,
  parameter int DEAD_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [1:0]       wrAddr,
  input  logic [CNT_W-1:0] wrData,
  output logic             pwmOut,
  output logic             pwmOutN,
  output logic [CNT_W-1:0] count
);
  pwmStrobe_t        strobe;
  logic              polarity;
  logic [DEAD_W-1:0] deadTicks;
  logic [CNT_W-1:0]  pwmVal;
  logic [CNT_W-1:0]  reloadVal;

  pwm_dt_ctrl #(.CNT_W(CNT_W), .PRES_W(PRES_W), .DEAD_W(DEAD_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .strobe(strobe), .polarity(polarity), .deadTicks(deadTicks),
    .pwmVal(pwmVal), .reloadVal(reloadVal)
  );

  pwm_dt_datapath #(.CNT_W(CNT_W), .DEAD_W(DEAD_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .polarity(polarity),
    .deadTicks(deadTicks), .pwmVal(pwmVal), .reloadVal(reloadVal),
    .pwmOut(pwmOut), .pwmOutN(pwmOutN), .count(count)
  );
endmodule

// File: tb/pwm_deadband_timer_bench.sv
module pwm_deadband_timer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;

  typedef struct packed {
    logic [2:0]  pres;
    logic [2:0]  dead;
    logic        pol;
    logic [15:0] pwm;
    logic [15:0] rld;
    logic [15:0] expPri;   // primary high clocks per period
    logic [15:0] expComp;  // complement high clocks per period
  } vec_t;

  // Expected values from R4/R5/R6: high ticks minus dead ticks, times 2^pres
  localparam vec_t VECS [NVEC] = '{
    '{3'd0, 3'd0, 1'b1, 16'd4, 16'd10, 16'd7,   16'd3},
    '{3'd0, 3'd2, 1'b1, 16'd4, 16'd10, 16'd5,   16'd1},
    '{3'd1, 3'd1, 1'b0, 16'd3, 16'd8,  16'd2,   16'd10},
    '{3'd2, 3'd3, 1'b1, 16'd6, 16'd12, 16'd16,  16'd8},
    '{3'd0, 3'd7, 1'b1, 16'd9, 16'd12, 16'd0,   16'd1},
    '{3'd3, 3'd0, 1'b1, 16'd2, 16'd5,  16'd32,  16'd8},
    '{3'd0, 3'd0, 1'b1, 16'd1, 16'd6,  16'd6,   16'd0},
    '{3'd7, 3'd1, 1'b1, 16'd2, 16'd3,  16'd128, 16'd0}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic        pwmOut, pwmOutN;
  logic [15:0] count;

  int total = 0;
  int failed = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_deadband_timer u_pwm_deadband_timer (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .pwmOut(pwmOut), .pwmOutN(pwmOutN), .count(count)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      failed++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // R1 control word: bit0 enable, bit1 polarity, [4:2] prescale, [7:5] dead
  function automatic logic [15:0] mkCtrl(input logic en, input logic pol,
                                         input logic [2:0] p, input logic [2:0] dt);
    return {8'd0, dt, p, pol, en};
  endfunction

  task automatic measure(input int cycles, output int hiP, output int hiC, output int both);
    hiP = 0; hiC = 0; both = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (pwmOut) hiP++;
      if (pwmOutN) hiC++;
      if (pwmOut && pwmOutN) both++;
    end
  endtask

  initial begin
    int hiP, hiC, both, period, c0;
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9 pwmOut at reset", int'(pwmOut), 0);
    chk("R9 pwmOutN at reset", int'(pwmOutN), 0);
    chk("R9 count at reset", int'(count), 0);
    rstN = 1'b1;

    // R3: count sequence 1..5 then back to 1, prescale 1
    wr(2'd2, 16'd5);
    wr(2'd1, 16'd3);
    wr(2'd0, mkCtrl(1'b1, 1'b1, 3'd0, 3'd0));
    chk("R3 count before first tick", int'(count), 0);
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk);
      chk("R3 count sequence", int'(count), ((k - 1) % 5) + 1);
    end

    // R1/R4/R5/R6/R8: vector table over whole periods
    for (int v = 0; v < NVEC; v++) begin
      wr(2'd0, mkCtrl(1'b0, VECS[v].pol, VECS[v].pres, VECS[v].dead));
      wr(2'd1, VECS[v].pwm);
      wr(2'd2, VECS[v].rld);
      wr(2'd0, mkCtrl(1'b1, VECS[v].pol, VECS[v].pres, VECS[v].dead));
      period = int'(VECS[v].rld) << VECS[v].pres;
      repeat (3 * period + (8 << VECS[v].pres)) @(negedge clk);
      measure(2 * period, hiP, hiC, both);
      chk($sformatf("R4 R6 primary high clocks vec%0d", v), hiP, 2 * int'(VECS[v].expPri));
      chk($sformatf("R5 R6 complement high clocks vec%0d", v), hiC, 2 * int'(VECS[v].expComp));
      chk($sformatf("R8 overlap cycles vec%0d", v), both, 0);
    end

    // R1: spare address write has no effect on the running waveform (vector 0 setup)
    wr(2'd0, mkCtrl(1'b0, 1'b1, 3'd0, 3'd0));
    wr(2'd1, 16'd4);
    wr(2'd2, 16'd10);
    wr(2'd0, mkCtrl(1'b1, 1'b1, 3'd0, 3'd0));
    wr(2'd3, 16'hFFFF);
    repeat (40) @(negedge clk);
    measure(20, hiP, hiC, both);
    chk("R1 spare write primary", hiP, 14);
    chk("R1 spare write complement", hiC, 6);

    // R7: disabled holds count, outputs low
    wr(2'd0, mkCtrl(1'b0, 1'b1, 3'd0, 3'd0));
    c0 = int'(count);
    measure(25, hiP, hiC, both);
    chk("R7 primary low when off", hiP, 0);
    chk("R7 complement low when off", hiC, 0);
    chk("R7 count held", int'(count), c0);

    // R2: prescale 4, restart alignment twice
    wr(2'd2, 16'd1000);
    for (int rep = 0; rep < 2; rep++) begin
      wr(2'd0, mkCtrl(1'b0, 1'b1, 3'd2, 3'd0));
      c0 = int'(count);
      wr(2'd0, mkCtrl(1'b1, 1'b1, 3'd2, 3'd0));
      repeat (3) @(negedge clk);
      chk("R2 no advance before 4th edge", int'(count), c0);
      @(negedge clk);
      chk("R2 advance on 4th edge", int'(count), c0 + 1);
      repeat (6) @(negedge clk);
      chk("R2 next tick 4 edges later", int'(count), c0 + 2);
      @(negedge clk);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      failed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end
endmodule